// File: doc/BRIEF.md
# Line Error Counters with Status

This block accumulates error events reported by a line framer and presents them to a host as counters and latched status bits. Four counters saturate at their maximum value: one for bipolar violations, one for CRC errors, one for out-of-frame events and one for framing-bit errors. An 8-bit status register latches counter saturation, framing-bit errors, a severe framing condition (two errored framing bits among the last six received) and the moment a carrier-loss or blue-alarm condition clears. A mask register of the same layout selects which status bits pull the active-low interrupt output.

The host reads registers through a single-cycle read strobe with an address. Data is returned combinationally in the cycle of the strobe. Reading a counter or the status register clears it at the end of that cycle. An event that arrives in the same cycle is not lost.

Top module: `line_err_mon`

## Requirements
- R1: After synchronous active-low reset, every counter, the status register and the mask register read as zero, and irq_n is 1.
- R2: Each event input that is high at a clock edge adds one to its counter. The bipolar violation counter is 16 bits wide and the other three counters are 8 bits wide.
- R3: A counter that holds its maximum value (65535 for the 16-bit counter, 255 for the 8-bit counters) stays at that value when further events arrive.
- R4: A saturation bit is set only by an event that arrives while its counter already holds its maximum value and is not being read. Reaching the maximum does not set it. The saturation bits are at these positions: bit 0 for the bipolar violation counter, bit 1 for CRC, bit 2 for out-of-frame and bit 3 for framing-bit errors.
- R5: Status bit 7 is set when a valid framing bit arrives and at least 2 of the last 6 valid framing bits, counting the new one, are in error.
- R6: Status bit 6 is set on the cycle after carrier_loss falls from 1 to 0. Status bit 5 is set on the cycle after blue_alarm falls from 1 to 0. Both bits stay set until the status register is read.
- R7: Status bit 4 is set by a framing-bit error event.
- R8: A read of the status register returns the current value and clears all bits, except a bit whose set condition occurs in the same cycle. That bit reads as set afterwards.
- R9: A read of a counter returns its value and resets the counter. If an event arrives in the same cycle, the counter holds 1 afterwards.
- R10: irq_n is 0 exactly when some status bit and its mask bit are both 1. A mask bit of 1 enables that bit. Writing the mask does not change the status register.
- R11: The read address map is: 0 for status, 1 for mask, 2 for the bipolar violation count, 3 for CRC, 4 for out-of-frame and 5 for framing-bit errors. Addresses 6 and 7 read as zero. Reading the mask clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_bpv | input | 1 | Bipolar violation event |
| ev_crc | input | 1 | CRC error event |
| ev_oof | input | 1 | Out-of-frame event |
| ev_fbe | input | 1 | Framing-bit error event |
| fbit_vld | input | 1 | A framing bit was received this cycle |
| fbit_err | input | 1 | That framing bit was in error |
| carrier_loss | input | 1 | Carrier-loss level |
| blue_alarm | input | 1 | Blue alarm (all-ones) level |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, valid during rd_en |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Read data is combinational, so the value is due in the same cycle as the strobe. Counter and status effects of an event appear one clock edge later. The interrupt follows one edge after the status or mask register changes. The bench applies stimulus just after a falling edge and compares rd_data and irq_n a little before the next rising edge. It updates its behavioural model only after that rising edge, so every comparison uses the state left by earlier edges. The corner cases that depend on timing are exercised in a single cycle each: a read together with an event, the 255th and 256th events, and the falling edge of an alarm.

// File: rtl/lem_pkg.sv
// Package: shared widths, register addresses and status bit positions
// for the line error monitor. Assumes a 3-bit read address.
package lem_pkg;
    localparam int BPV_W  = 16;
    localparam int ERR_W  = 8;
    localparam int STAT_W = 8;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;

    typedef enum logic [ADDR_W-1:0] {
        A_STATUS = 3'd0,
        A_MASK   = 3'd1,
        A_BPV    = 3'd2,
        A_CRC    = 3'd3,
        A_OOF    = 3'd4,
        A_FBE    = 3'd5
    } reg_addr_e;

    localparam int S_BPV_SAT = 0;
    localparam int S_CRC_SAT = 1;
    localparam int S_OOF_SAT = 2;
    localparam int S_FBE_SAT = 3;
    localparam int S_FERR    = 4;
    localparam int S_BLUE_CL = 5;
    localparam int S_CARR_CL = 6;
    localparam int S_SEVERE  = 7;
endpackage

// File: rtl/lem_sat_counter.sv
// Saturating event counter with clear-on-read.
// It assumes inc is a single-cycle event. When clr is high, the counter
// restarts from 0, or from 1 if inc is high in the same cycle.
// sat_hit flags an event that finds the counter already at its maximum.
module lem_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         sat_hit
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    logic at_max;
    assign at_max  = (cnt == MAX);
    assign sat_hit = inc && at_max && !clr;

    // Count events, hold at maximum, restart on read.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= W'(inc);
        else if (inc && !at_max) cnt <= cnt + 1'b1;
    end

    a_r3_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && !clr) |=> (cnt == MAX));
    a_r9_read_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt <= W'(1)));
endmodule

// File: rtl/lem_frame_window.sv
// Severe framing detector over a sliding window of framing-bit results.
// It assumes fbit_vld marks one received framing bit and fbit_err flags
// that bit as errored. hit fires when the window, including the new bit,
// holds at least THRESH errors.
module lem_frame_window #(
    parameter int DEPTH  = 6,
    parameter int THRESH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fbit_vld,
    input  logic fbit_err,
    output logic hit
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] hist;
    logic [DEPTH-1:0] hist_nxt;
    logic [CW-1:0]    nerr;

    assign hist_nxt = {hist[DEPTH-2:0], fbit_err};

    // Count the errors in the window as it will stand after the new bit.
    always_comb begin
        nerr = '0;
        for (int i = 0; i < DEPTH; i++) nerr = nerr + CW'(hist_nxt[i]);
    end

    assign hit = fbit_vld && (nerr >= CW'(THRESH));

    // Shift in each valid framing-bit result.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist <= '0;
        else if (fbit_vld) hist <= hist_nxt;
    end

    a_r5_only_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !fbit_vld |-> !hit);
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !fbit_vld |=> $stable(hist));
endmodule

// File: rtl/lem_status.sv
// Latched status register. set bits latch at the clock edge. clr (a
// status read) drops every bit, except the bits that are set in the same
// cycle.
module lem_status #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] stat
);
    // Latch new conditions and apply clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (clr ? '0 : stat) | set;
    end

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set == '0) |=> (stat == '0));
    a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/line_err_mon.sv
// Top of the line error monitor. It assumes the event inputs are
// single-cycle pulses from a framer and the alarm inputs are levels
// synchronous to clk. Read data is combinational during rd_en. Clear-on-
// read takes effect at the clock edge that ends the read cycle.
module line_err_mon
    import lem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_bpv,
    input  logic              ev_crc,
    input  logic              ev_oof,
    input  logic              ev_fbe,
    input  logic              fbit_vld,
    input  logic              fbit_err,
    input  logic              carrier_loss,
    input  logic              blue_alarm,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic              irq_n
);
    localparam int N8 = 3;

    logic [BPV_W-1:0]  bpv_cnt;
    logic              bpv_sat;
    logic [ERR_W-1:0]  cnt8 [N8];
    logic [N8-1:0]     sat8;
    logic [N8-1:0]     ev8;
    logic [N8-1:0]     clr8;
    logic              severe;
    logic [STAT_W-1:0] stat_set;
    logic [STAT_W-1:0] stat;
    logic [STAT_W-1:0] mask;
    logic              carr_q;
    logic              blue_q;

    assign ev8  = {ev_fbe, ev_oof, ev_crc};
    assign clr8 = {rd_en && rd_addr == A_FBE,
                   rd_en && rd_addr == A_OOF,
                   rd_en && rd_addr == A_CRC};

    lem_sat_counter #(.W(BPV_W)) u_bpv (
        .clk(clk), .rst_n(rst_n), .inc(ev_bpv),
        .clr(rd_en && rd_addr == A_BPV), .cnt(bpv_cnt), .sat_hit(bpv_sat));

    for (genvar g = 0; g < N8; g++) begin : g_cnt8
        lem_sat_counter #(.W(ERR_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(ev8[g]), .clr(clr8[g]),
            .cnt(cnt8[g]), .sat_hit(sat8[g]));
    end

    lem_frame_window #(.DEPTH(6), .THRESH(2)) u_win (
        .clk(clk), .rst_n(rst_n), .fbit_vld(fbit_vld),
        .fbit_err(fbit_err), .hit(severe));

    // Remember the alarm levels to find their falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carr_q <= 1'b0;
            blue_q <= 1'b0;
        end else begin
            carr_q <= carrier_loss;
            blue_q <= blue_alarm;
        end
    end

    // Gather the conditions that set each status bit.
    always_comb begin
        stat_set            = '0;
        stat_set[S_BPV_SAT] = bpv_sat;
        stat_set[S_CRC_SAT] = sat8[0];
        stat_set[S_OOF_SAT] = sat8[1];
        stat_set[S_FBE_SAT] = sat8[2];
        stat_set[S_FERR]    = ev_fbe;
        stat_set[S_BLUE_CL] = blue_q && !blue_alarm;
        stat_set[S_CARR_CL] = carr_q && !carrier_loss;
        stat_set[S_SEVERE]  = severe;
    end

    lem_status #(.W(STAT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .set(stat_set),
        .clr(rd_en && rd_addr == A_STATUS), .stat(stat));

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    assign irq_n = ~|(stat & mask);

    // Read data mux.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (rd_addr)
                A_STATUS: rd_data = DATA_W'(stat);
                A_MASK:   rd_data = DATA_W'(mask);
                A_BPV:    rd_data = DATA_W'(bpv_cnt);
                A_CRC:    rd_data = DATA_W'(cnt8[0]);
                A_OOF:    rd_data = DATA_W'(cnt8[1]);
                A_FBE:    rd_data = DATA_W'(cnt8[2]);
                default:  rd_data = '0;
            endcase
        end
    end

    a_r4_bpv_sat_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[S_BPV_SAT]) |-> ($past(bpv_cnt) == {BPV_W{1'b1}}));
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> irq_n);
    a_r6_carrier_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[S_CARR_CL]) |-> $past(carr_q && !carrier_loss));
endmodule

// File: tb/line_err_mon_tb.sv
`timescale 1ns/1ps
module line_err_mon_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_bpv = 0, ev_crc = 0, ev_oof = 0, ev_fbe = 0;
    logic        fbit_vld = 0, fbit_err = 0;
    logic        carrier_loss = 0, blue_alarm = 0;
    logic        rd_en = 0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        mask_we = 0;
    logic [7:0]  mask_wdata = '0;
    logic        irq_n;

    always #5 clk = ~clk;

    line_err_mon u_dut (
        .clk(clk), .rst_n(rst_n), .ev_bpv(ev_bpv), .ev_crc(ev_crc),
        .ev_oof(ev_oof), .ev_fbe(ev_fbe), .fbit_vld(fbit_vld),
        .fbit_err(fbit_err), .carrier_loss(carrier_loss),
        .blue_alarm(blue_alarm), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .irq_n(irq_n));

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // Behavioural reference model.
    int unsigned m_cnt [4];
    int unsigned m_max [4] = '{65535, 255, 255, 255};
    bit [7:0] m_stat, m_mask;
    bit       win [$];
    bit       p_carr, p_blue;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_rd(int a);
        case (a)
            0: return m_stat;
            1: return m_mask;
            2, 3, 4, 5: return m_cnt[a-2];
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        m_stat = 0; m_mask = 0; win.delete(); p_carr = 0; p_blue = 0;
    endtask

    // Model update for one clock edge with the present input values.
    task automatic model_step();
        bit [3:0] ev;
        bit [7:0] set;
        int nerr;
        ev = {ev_fbe, ev_oof, ev_crc, ev_bpv};
        set = 0;
        for (int i = 0; i < 4; i++) begin
            bit rd;
            rd = rd_en && (rd_addr == 3'(i + 2));
            if (rd) m_cnt[i] = ev[i] ? 1 : 0;
            else if (ev[i]) begin
                if (m_cnt[i] == m_max[i]) set[i] = 1;
                else m_cnt[i]++;
            end
        end
        if (ev_fbe) set[4] = 1;
        if (p_blue && !blue_alarm) set[5] = 1;
        if (p_carr && !carrier_loss) set[6] = 1;
        if (fbit_vld) begin
            win.push_back(fbit_err);
            if (win.size() > 6) void'(win.pop_front());
            nerr = 0;
            foreach (win[k]) nerr += win[k];
            if (nerr >= 2) set[7] = 1;
        end
        if (rd_en && rd_addr == 0) m_stat = 0;
        m_stat |= set;
        if (mask_we) m_mask = mask_wdata;
        p_carr = carrier_loss; p_blue = blue_alarm;
    endtask

    // One cycle: inputs set just after negedge, compare before posedge,
    // update the model at the edge, then clear the pulse inputs.
    task automatic cyc();
        #3;
        chk({cur_req, " irq_n"}, irq_n, (m_stat & m_mask) != 0 ? 0 : 1);
        if (rd_en) chk({cur_req, " rd_data"}, rd_data, exp_rd(rd_addr));
        @(posedge clk);
        model_step();
        @(negedge clk);
        ev_bpv = 0; ev_crc = 0; ev_oof = 0; ev_fbe = 0;
        fbit_vld = 0; fbit_err = 0; rd_en = 0; mask_we = 0;
    endtask

    task automatic rd(int a);
        rd_en = 1; rd_addr = 3'(a);
        cyc();
    endtask

    task automatic fbit(bit e);
        fbit_vld = 1; fbit_err = e;
        cyc();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state through every address; R11: unused addresses.
        cur_req = "R1";
        for (int a = 0; a < 6; a++) rd(a);
        cur_req = "R11";
        rd(6); rd(7);

        // R2: counting on several patterns.
        cur_req = "R2";
        for (int i = 0; i < 5; i++) begin
            ev_bpv = 1; ev_crc = (i % 2 == 0); ev_oof = (i < 2); cyc();
        end
        ev_fbe = 1; cyc();
        for (int a = 2; a < 6; a++) rd(a);
        // R7: a framing-bit error event sets bit 4.
        cur_req = "R7";
        rd(0);
        // R8: a status read together with a new set condition.
        cur_req = "R8";
        ev_fbe = 1; rd(0);
        rd(0);
        rd(0);
        // R9: a counter read together with an event.
        cur_req = "R9";
        ev_crc = 1; rd(3);
        rd(3);
        rd(0);

        // R3 and R4 on the CRC counter.
        cur_req = "R3";
        for (int i = 0; i < 255; i++) begin ev_crc = 1; cyc(); end
        cur_req = "R4";
        rd(0);
        ev_crc = 1; cyc();
        rd(0);
        cur_req = "R3";
        rd(3);
        // R4: an event in the cycle that reads a full counter.
        cur_req = "R4";
        for (int i = 0; i < 255; i++) begin ev_oof = 1; cyc(); end
        ev_oof = 1; rd(4);
        rd(0);
        // R3 and R4 on the 16-bit counter.
        cur_req = "R3";
        for (int i = 0; i < 65535; i++) begin ev_bpv = 1; cyc(); end
        rd(0);
        ev_bpv = 1; cyc(); ev_bpv = 1; cyc();
        rd(2);
        cur_req = "R4";
        rd(0);

        // R5: two errors six bits apart do not trigger; closer ones do.
        cur_req = "R5";
        fbit(1); for (int i = 0; i < 5; i++) fbit(0); fbit(1);
        rd(0);
        fbit(0); fbit(1);
        rd(0);
        rd(0);

        // R6: falling edges of both alarms.
        cur_req = "R6";
        carrier_loss = 1; cyc(); cyc();
        rd(0);
        carrier_loss = 0; cyc();
        blue_alarm = 1; cyc();
        blue_alarm = 0; cyc();
        cyc();
        rd(0);
        rd(0);

        // R10: mask enables the interrupt; a mask write leaves status alone.
        cur_req = "R10";
        mask_we = 1; mask_wdata = 8'h10; cyc();
        rd(1);
        ev_fbe = 1; cyc();
        cyc();
        rd(0);
        cyc();
        mask_we = 1; mask_wdata = 8'h00; cyc();
        ev_fbe = 1; cyc();
        cyc();
        mask_we = 1; mask_wdata = 8'hFF; cyc();
        cyc();
        rd(0);
        rd(0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule